// File: doc/BRIEF.md
# USB Root-Hub Downstream Port Status Register

This block holds the status and control word for one downstream port of a USB host root hub. Software reaches it over a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. On the port side it tracks attach and detach events, a strap that marks a fixed (non-removable) device, and completion pulses from the port reset and resume timers, which live outside the block.

Each command bit in the word reads back one piece of status but acts as a one-shot command on write. Writing 1 sets or clears port state, and the command may be refused or redirected depending on whether a device is connected. Writing 0 never changes anything. Change flags latch the events that software must notice, and a flag is cleared by writing 1 to it. When a hardware event and a software write hit the same bit in one cycle, the hardware event wins, and a change flag that is both raised and acknowledged in one cycle stays set.

The port is connected if a device is attached or the fixed-device strap is high. When a port loses its connection, its enable, suspend and reset states are dropped at once.

Top module: `usb_port_status`

## Requirements
- R1: Synchronous active-high reset clears every field, so the register reads 0x00000000.
- R2: Bit 0 reads 1 from the cycle after an attach pulse until the cycle after a detach pulse. While the fixed-device input is high, bit 0 reads 1 regardless of detach.
- R3: Writing a word with bit 0 set clears port-enable (bit 1). Writing a word of all zeros changes no bit.
- R4: Writing a word with bit 1 set sets port-enable only when bit 0 reads 1. Otherwise the write has no effect.
- R5: Writing bit 4 while connected sets port-reset status (bit 4). A reset-done pulse while bit 4 is 1 clears bit 4 and bit 2 and sets bit 1. Bit 20 is set whenever bit 4 changes. Writing bit 4 while disconnected does nothing.
- R6: A resume-done pulse while bit 2 is 1 clears bit 2, sets bit 1 and sets the suspend-change flag (bit 18).
- R7: Writing bit 2 while connected sets suspend status (bit 2). Writing bit 2 while disconnected leaves bit 2 at 0 and sets the connect-change flag (bit 16).
- R8: Bit 16 is set on every change of bit 0. A loss of connection clears bits 1, 2, 4 and 9 in the same cycle, and it sets bit 17 if bit 1 was 1.
- R9: Writing 1 to bit 16, 17, 18 or 20 clears that flag. A flag that is raised and cleared in the same cycle stays set.
- R10: When a resume-done or reset-done event and a bit-0 clear write hit port-enable in the same cycle, port-enable ends at 1.
- R11: Writing bit 8 sets port-power (bit 8). Writing bit 9 clears it, and the clear wins if both bits are written. Bit 9 reads the low-speed input as captured on attach, and reads 0 once the port is disconnected.
- R12: Bits 31:21 and bits 3, 5 to 7, 10 to 15 and 19 read 0. A read at any other address returns 0, and a write at any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 unless the address matches |
| dev_attach | input | 1 | One-cycle pulse: a device attached |
| dev_detach | input | 1 | One-cycle pulse: the device detached; wins over attach |
| dev_low_speed | input | 1 | Speed of the attaching device, sampled on attach |
| fixed_dev | input | 1 | Strap: a non-removable device is present |
| reset_done | input | 1 | One-cycle pulse: the port reset timer expired |
| resume_done | input | 1 | One-cycle pulse: the resume sequence finished |

## Verification
The assertions assume that reset is held for at least two cycles. They also assume that reset-done and resume-done arrive only as single-cycle pulses, so the enable and suspend rises they check always follow a cycle in which the port was connected. The stimulus keeps each event input high for exactly one cycle. It drives every input on the falling edge and holds reset for three cycles. A behavioural model in the bench predicts the full word on every clock, including the same-cycle collisions of events with writes.

// File: rtl/usbp_pkg.sv
package usbp_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_FLAGS = 4;

    // field positions inside the status word
    localparam int BIT_CCS  = 0;
    localparam int BIT_PES  = 1;
    localparam int BIT_PSS  = 2;
    localparam int BIT_PRS  = 4;
    localparam int BIT_PPS  = 8;
    localparam int BIT_LSDA = 9;
    localparam int BIT_CSC  = 16;
    localparam int BIT_PESC = 17;
    localparam int BIT_PSSC = 18;
    localparam int BIT_PRSC = 20;

    // index of each change flag in the flag vector
    typedef enum logic [1:0] {
        FLG_CONN = 2'd0,
        FLG_ENA  = 2'd1,
        FLG_SUSP = 2'd2,
        FLG_RST  = 2'd3
    } flag_e;

    // decoded one-shot write commands
    typedef struct packed {
        logic                 clr_ena;
        logic                 set_ena;
        logic                 req_susp;
        logic                 req_rst;
        logic                 pwr_on;
        logic                 pwr_off;
        logic [NUM_FLAGS-1:0] ack;
    } cmd_t;

    // architectural state of the port
    typedef struct packed {
        logic                 ccs;
        logic                 lsda;
        logic                 pes;
        logic                 pss;
        logic                 prs;
        logic                 pps;
        logic [NUM_FLAGS-1:0] chg;
    } stat_t;

    function automatic int flag_bit(input int idx);
        case (idx)
            0:       return BIT_CSC;
            1:       return BIT_PESC;
            2:       return BIT_PSSC;
            default: return BIT_PRSC;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input stat_t s);
        logic [WORD_W-1:0] w;
        w           = '0;
        w[BIT_CCS]  = s.ccs;
        w[BIT_PES]  = s.pes;
        w[BIT_PSS]  = s.pss;
        w[BIT_PRS]  = s.prs;
        w[BIT_PPS]  = s.pps;
        w[BIT_LSDA] = s.lsda;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            w[flag_bit(i)] = s.chg[i];
        end
        return w;
    endfunction

endpackage

// File: rtl/usbp_wr_decode.sv
module usbp_wr_decode
    import usbp_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic              hit,
    output cmd_t              cmd
);

    logic wr_hit;
    logic unused_wdata;

    assign hit    = (addr == REG_ADDR);
    assign wr_hit = hit & wr;

    always_comb begin
        cmd          = '0;
        cmd.clr_ena  = wr_hit & wdata[BIT_CCS];
        cmd.set_ena  = wr_hit & wdata[BIT_PES];
        cmd.req_susp = wr_hit & wdata[BIT_PSS];
        cmd.req_rst  = wr_hit & wdata[BIT_PRS];
        cmd.pwr_on   = wr_hit & wdata[BIT_PPS];
        cmd.pwr_off  = wr_hit & wdata[BIT_LSDA];
        for (int i = 0; i < NUM_FLAGS; i++) begin
            cmd.ack[i] = wr_hit & wdata[flag_bit(i)];
        end
    end

    assign unused_wdata = ^wdata;

endmodule

// File: rtl/usbp_conn_track.sv
module usbp_conn_track (
    input  logic clk,
    input  logic rst,
    input  logic attach,
    input  logic detach,
    input  logic strap,
    input  logic low_speed,
    output logic ccs,
    output logic lsda,
    output logic ccs_chg,
    output logic disc
);

    logic attached_q, attached_n;
    logic ccs_q, ccs_n;
    logic lsda_q, lsda_n;

    always_comb begin
        attached_n = attached_q;
        if (attach) attached_n = 1'b1;
        if (detach) attached_n = 1'b0;
        ccs_n = attached_n | strap;

        lsda_n = lsda_q;
        if (attach && !detach) lsda_n = low_speed;
        if (!ccs_n)            lsda_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            attached_q <= 1'b0;
            ccs_q      <= 1'b0;
            lsda_q     <= 1'b0;
        end else begin
            attached_q <= attached_n;
            ccs_q      <= ccs_n;
            lsda_q     <= lsda_n;
        end
    end

    assign ccs     = ccs_q;
    assign lsda    = lsda_q;
    assign ccs_chg = ccs_n ^ ccs_q;
    assign disc    = ccs_q & ~ccs_n;

    // R11: speed indication never shows without a connection
    a_r11_lsda_needs_conn: assert property (@(posedge clk) disable iff (rst)
        lsda_q |-> ccs_q);

    // R2: the strap keeps the port connected
    a_r2_strap_forces_conn: assert property (@(posedge clk) disable iff (rst)
        $past(strap) |-> ccs_q);

endmodule

// File: rtl/usbp_port_ctrl.sv
module usbp_port_ctrl
    import usbp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  cmd_t                 cmd,
    input  logic                 ccs,
    input  logic                 ccs_chg,
    input  logic                 disc,
    input  logic                 reset_done,
    input  logic                 resume_done,
    output logic                 pes,
    output logic                 pss,
    output logic                 prs,
    output logic                 pps,
    output logic [NUM_FLAGS-1:0] chg
);

    logic pes_q, pes_n;
    logic pss_q, pss_n;
    logic prs_q, prs_n;
    logic pps_q, pps_n;
    logic rst_evt, res_evt;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] chg_q;

    // completion events only count for a sequence that is in progress
    assign rst_evt = reset_done  & prs_q;
    assign res_evt = resume_done & pss_q;

    // later assignments have priority: software, then hardware, then disconnect
    always_comb begin
        pes_n = pes_q;
        if (cmd.set_ena && ccs)   pes_n = 1'b1;
        if (cmd.clr_ena)          pes_n = 1'b0;
        if (rst_evt || res_evt)   pes_n = 1'b1;
        if (disc)                 pes_n = 1'b0;

        pss_n = pss_q;
        if (cmd.req_susp && ccs)  pss_n = 1'b1;
        if (rst_evt || res_evt)   pss_n = 1'b0;
        if (disc)                 pss_n = 1'b0;

        prs_n = prs_q;
        if (cmd.req_rst && ccs)   prs_n = 1'b1;
        if (rst_evt)              prs_n = 1'b0;
        if (disc)                 prs_n = 1'b0;

        pps_n = pps_q;
        if (cmd.pwr_on)           pps_n = 1'b1;
        if (cmd.pwr_off)          pps_n = 1'b0;
    end

    always_comb begin
        flag_set           = '0;
        flag_set[FLG_CONN] = ccs_chg | (cmd.req_susp & ~ccs);
        flag_set[FLG_ENA]  = disc & pes_q;
        flag_set[FLG_SUSP] = res_evt;
        flag_set[FLG_RST]  = prs_n ^ prs_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pes_q <= 1'b0;
            pss_q <= 1'b0;
            prs_q <= 1'b0;
            pps_q <= 1'b0;
        end else begin
            pes_q <= pes_n;
            pss_q <= pss_n;
            prs_q <= prs_n;
            pps_q <= pps_n;
        end
    end

    // one sticky change flag per event class; a new event beats the acknowledge
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) chg_q[g] <= 1'b0;
            else     chg_q[g] <= flag_set[g] | (chg_q[g] & ~cmd.ack[g]);
        end
    end

    assign pes = pes_q;
    assign pss = pss_q;
    assign prs = prs_q;
    assign pps = pps_q;
    assign chg = chg_q;

    // R4: the port only becomes enabled out of a connected cycle
    a_r4_enable_needs_conn: assert property (@(posedge clk) disable iff (rst)
        $rose(pes_q) |-> $past(ccs));

    // R7: suspend is only entered from a connected cycle
    a_r7_suspend_needs_conn: assert property (@(posedge clk) disable iff (rst)
        $rose(pss_q) |-> $past(ccs));

    // R8: no enable, suspend or reset state survives without a connection
    a_r8_disc_drops_state: assert property (@(posedge clk) disable iff (rst)
        !ccs |-> (!pes_q && !pss_q && !prs_q));

    // R5: every change of reset status leaves its change flag set
    a_r5_reset_change_flag: assert property (@(posedge clk) disable iff (rst)
        (prs_q != $past(prs_q)) |-> chg_q[FLG_RST]);

    // R6: leaving suspend while still connected leaves the port enabled
    a_r6_leave_suspend_enables: assert property (@(posedge clk) disable iff (rst)
        ($fell(pss_q) && ccs) |-> pes_q);

endmodule

// File: rtl/usb_port_status.sv
module usb_port_status
    import usbp_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = 12'h010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              dev_attach,
    input  logic              dev_detach,
    input  logic              dev_low_speed,
    input  logic              fixed_dev,
    input  logic              reset_done,
    input  logic              resume_done
);

    logic  hit;
    cmd_t  cmd;
    stat_t st;
    logic  ccs_chg, disc;

    usbp_wr_decode #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_dec (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .wdata (bus_wdata),
        .hit   (hit),
        .cmd   (cmd)
    );

    usbp_conn_track u_conn (
        .clk       (clk),
        .rst       (rst),
        .attach    (dev_attach),
        .detach    (dev_detach),
        .strap     (fixed_dev),
        .low_speed (dev_low_speed),
        .ccs       (st.ccs),
        .lsda      (st.lsda),
        .ccs_chg   (ccs_chg),
        .disc      (disc)
    );

    usbp_port_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .ccs         (st.ccs),
        .ccs_chg     (ccs_chg),
        .disc        (disc),
        .reset_done  (reset_done),
        .resume_done (resume_done),
        .pes         (st.pes),
        .pss         (st.pss),
        .prs         (st.prs),
        .pps         (st.pps),
        .chg         (st.chg)
    );

    assign bus_rdata = hit ? pack_status(st) : '0;

    // R12: a foreign address never returns data
    a_r12_foreign_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != REG_ADDR) |-> (bus_rdata == '0));

endmodule

// File: tb/usb_port_status_tb.sv
module usb_port_status_tb;

    localparam int          AW   = 12;
    localparam logic [11:0] RA   = 12'h010;
    localparam logic [11:0] OTHER = 12'h014;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = RA;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dev_attach = 1'b0, dev_detach = 1'b0, dev_low_speed = 1'b0;
    logic        fixed_dev = 1'b0, reset_done = 1'b0, resume_done = 1'b0;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_tag = "R1";

    always #10 clk = ~clk;

    usb_port_status #(.ADDR_W(AW), .REG_ADDR(RA)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_attach(dev_attach), .dev_detach(dev_detach),
        .dev_low_speed(dev_low_speed), .fixed_dev(fixed_dev),
        .reset_done(reset_done), .resume_done(resume_done)
    );

    // behavioural reference state
    bit m_att, m_conn, m_ls, m_en, m_sus, m_rs, m_pw;
    bit m_fc, m_fe, m_fs, m_fr;

    function automatic logic [31:0] model_word();
        logic [31:0] w = 0;
        w[0] = m_conn; w[1] = m_en; w[2] = m_sus; w[4] = m_rs;
        w[8] = m_pw;   w[9] = m_ls;
        w[16] = m_fc;  w[17] = m_fe; w[18] = m_fs; w[20] = m_fr;
        return w;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            {m_att, m_conn, m_ls, m_en, m_sus, m_rs, m_pw} = '0;
            {m_fc, m_fe, m_fs, m_fr} = '0;
        end else begin
            logic [31:0] w;
            bit att2, conn2, lost, rdone, sdone, en2, sus2, rs2;
            w     = (bus_wr && bus_addr == RA) ? bus_wdata : 32'h0;
            att2  = dev_detach ? 1'b0 : (dev_attach ? 1'b1 : m_att);
            conn2 = att2 | fixed_dev;
            lost  = m_conn && !conn2;
            rdone = reset_done && m_rs;
            sdone = resume_done && m_sus;
            en2 = m_en; sus2 = m_sus; rs2 = m_rs;
            if (w[1] && m_conn) en2 = 1;
            if (w[0]) en2 = 0;
            if (w[2] && m_conn) sus2 = 1;
            if (w[4] && m_conn) rs2 = 1;
            if (rdone || sdone) begin en2 = 1; sus2 = 0; end
            if (rdone) rs2 = 0;
            if (lost) begin en2 = 0; sus2 = 0; rs2 = 0; end
            m_fc = (conn2 != m_conn) || (w[2] && !m_conn) || (m_fc && !w[16]);
            m_fe = (lost && m_en) || (m_fe && !w[17]);
            m_fs = sdone || (m_fs && !w[18]);
            m_fr = (rs2 != m_rs) || (m_fr && !w[20]);
            if (w[8]) m_pw = 1;
            if (w[9]) m_pw = 0;
            if (dev_attach && !dev_detach) m_ls = dev_low_speed;
            if (!conn2) m_ls = 0;
            m_att = att2; m_conn = conn2;
            m_en = en2; m_sus = sus2; m_rs = rs2;
        end
        #5;
        if (!rst) begin
            logic [31:0] exp_w;
            exp_w = (bus_addr == RA) ? model_word() : 32'h0;
            n_tests++;
            if (bus_rdata !== exp_w) begin
                n_fail++;
                $display("FAIL %s model: actual %08h expected %08h", cur_tag, bus_rdata, exp_w);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp_v);
        end
    endtask

    // one bus/event cycle, then back to idle
    task automatic cyc(input logic [11:0] a, input logic w, input logic [31:0] d,
                       input logic att, input logic det, input logic rdn, input logic sdn);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_wdata = d;
        dev_attach = att; dev_detach = det; reset_done = rdn; resume_done = sdn;
        @(negedge clk);
        bus_addr = RA; bus_wr = 0; bus_wdata = 0;
        dev_attach = 0; dev_detach = 0; reset_done = 0; resume_done = 0;
        #1;
    endtask

    task automatic wr(input logic [31:0] d);
        cyc(RA, 1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        cur_tag = "R1"; check("R1 reset value", bus_rdata, 32'h0);

        cur_tag = "R3"; wr(32'h0);
        check("R3 zero write", bus_rdata, 32'h0);

        cur_tag = "R4"; wr(32'h2);
        check("R4 enable refused when disconnected", bus_rdata, 32'h0);

        cur_tag = "R7"; wr(32'h4);
        check("R7 suspend on disconnected port", bus_rdata, 32'h0001_0000);
        cur_tag = "R9"; wr(32'h0001_0000);
        check("R9 ack connect change", bus_rdata, 32'h0);

        cur_tag = "R2"; dev_low_speed = 1;
        cyc(RA, 1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R2 attach shows connect, R11 speed, R8 change", bus_rdata, 32'h0001_0201);
        wr(32'h0001_0000);
        check("R9 ack after attach", bus_rdata, 32'h0000_0201);

        cur_tag = "R4"; wr(32'h2);
        check("R4 enable when connected", bus_rdata, 32'h0000_0203);
        cur_tag = "R3"; wr(32'h1);
        check("R3 bit0 clears enable", bus_rdata, 32'h0000_0201);

        cur_tag = "R5"; wr(32'h10);
        check("R5 reset start", bus_rdata, 32'h0010_0211);
        cyc(RA, 1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R5 reset done enables", bus_rdata, 32'h0010_0203);
        wr(32'h0010_0000);
        check("R9 ack reset change", bus_rdata, 32'h0000_0203);

        cur_tag = "R7"; wr(32'h4);
        check("R7 suspend connected", bus_rdata, 32'h0000_0207);
        cur_tag = "R10"; cyc(RA, 1'b1, 32'h1, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R10 R6 resume beats clear write", bus_rdata, 32'h0004_0203);

        cur_tag = "R9"; wr(32'h4);
        check("R7 suspend again", bus_rdata, 32'h0004_0207);
        cyc(RA, 1'b1, 32'h0004_0000, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R9 set beats ack", bus_rdata, 32'h0004_0203);
        wr(32'h0004_0000);
        check("R9 ack suspend change", bus_rdata, 32'h0000_0203);

        cur_tag = "R11"; wr(32'h100);
        check("R11 power on", bus_rdata, 32'h0000_0303);
        wr(32'h200);
        check("R11 power off", bus_rdata, 32'h0000_0203);
        wr(32'h300);
        check("R11 power clear wins", bus_rdata, 32'h0000_0203);

        cur_tag = "R5"; wr(32'h4); wr(32'h10);
        check("R5 reset while suspended", bus_rdata, 32'h0010_0217);
        cyc(RA, 1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R5 reset done leaves suspend", bus_rdata, 32'h0010_0203);
        wr(32'h0010_0000);

        cur_tag = "R8"; cyc(RA, 1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R8 detach drops state", bus_rdata, 32'h0003_0000);
        wr(32'h0003_0000);
        check("R9 ack both", bus_rdata, 32'h0);
        cur_tag = "R5"; wr(32'h10);
        check("R5 reset refused disconnected", bus_rdata, 32'h0);

        cur_tag = "R2"; dev_low_speed = 0;
        @(negedge clk); fixed_dev = 1;
        @(negedge clk); #1;
        check("R2 strap forces connect", bus_rdata, 32'h0001_0001);
        wr(32'h0001_0000);
        cyc(RA, 1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R2 detach ignored under strap", bus_rdata, 32'h0000_0001);
        @(negedge clk); fixed_dev = 0;
        @(negedge clk); #1;
        check("R2 strap release disconnects", bus_rdata, 32'h0001_0000);
        wr(32'h0001_0000);

        cur_tag = "R12"; cyc(RA, 1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b0);
        wr(32'h0001_0000);
        cyc(OTHER, 1'b1, 32'h0000_0002, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R12 foreign write ignored", bus_rdata, 32'h0000_0001);
        @(negedge clk); bus_addr = OTHER; #1;
        check("R12 foreign read zero", bus_rdata, 32'h0);
        bus_addr = RA;
        wr(32'hFFFF_FFFF);
        check("R12 all-ones write, reserved zero", bus_rdata, 32'h0010_0015);

        cur_tag = "R1";
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0; #1;
        check("R1 reset clears state", bus_rdata, 32'h0);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule